// File: doc/BRIEF.md
# Reference-Disciplined Phase Accumulator Oscillator

This block runs a numerically controlled oscillator, a phase accumulator that adds a control word on every clock, and steers that control word so the oscillator stays locked in frequency to a periodic external reference event. Each time the reference strobe arrives, the block captures the accumulator phase and compares it with the phase an ideal frame-aligned oscillator would hold at that instant. The wrapped, signed difference is the phase error. A proportional-plus-integral law turns this error into a new control word: the nominal word plus a shifted copy of the error plus a shifted copy of the running error sum.

The oscillator regenerates a one-clock pulse-per-second strobe by counting accumulator overflows. A lock flag reports that the error has stayed small for a programmable number of consecutive reference events. The gains are powers of two, applied as arithmetic right shifts, so the loop needs no multipliers.

Top module: `nco_pi_discipline`

## Requirements
- R1: The accumulator `phase` adds the current control word on every clock, modulo 2^ACC_W, and reads 0 after reset.
- R2: During and right after a synchronous reset (`rst_n` low), `fcw` equals `nominal_fcw`, the integral sum is 0, and `phase_err`, `pps` and `locked` are 0.
- R3: On a clock with `ref_strobe` high, the error is (`target_phase` − `phase`) modulo 2^ACC_W, read as two's complement in [−2^(ACC_W−1), 2^(ACC_W−1)−1]. A positive value means the local phase lags. The error appears on `phase_err` after that edge and holds until the next strobe.
- R4: `fcw` changes only on clocks with `ref_strobe` high.
- R5: On a strobe, the new `fcw` equals `nominal_fcw` + floor(err / 2^`kp_shift`) + floor(I / 2^`ki_shift`), clamped to [0, 2^ACC_W−1]. Here I is the integral sum after this error is added. A lagging error with a non-negative sum never lowers the word below nominal.
- R6: The integral sum saturates at −2^(INT_W−1) and 2^(INT_W−1)−1 and never wraps.
- R7: A strobe with |err| < `lock_thresh` raises a run counter that saturates at 2^LCK_W−1. `locked` is then the value of (counter ≥ `lock_need`). A strobe with |err| ≥ `lock_thresh` clears both the counter and `locked`. `locked` changes only on strobes.
- R8: `pps` is high for exactly the one clock after every PPS_WRAPS-th accumulator overflow, counted from reset, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_strobe | input | 1 | One-clock marker of a reference arrival |
| nominal_fcw | input | ACC_W | Free-running control word |
| target_phase | input | ACC_W | Ideal accumulator phase at a reference arrival |
| kp_shift | input | SH_W | Proportional gain as right-shift amount |
| ki_shift | input | SH_W | Integral gain as right-shift amount |
| lock_thresh | input | ACC_W | Error magnitude bound for a good arrival |
| lock_need | input | LCK_W | Consecutive good arrivals needed for lock |
| fcw | output | ACC_W | Current control word |
| phase | output | ACC_W | Accumulator phase |
| phase_err | output | ACC_W | Last captured signed phase error |
| pps | output | 1 | One-clock pulse-per-second strobe |
| locked | output | 1 | Lock indication |

## Verification
The loop is swept over a grid of proportional shifts, integral shifts, strobe periods and nominal-word offsets. Each run is compared against an arithmetic model every cycle. This separates errors in the rounding of negative shifts, in the order of integral update and control-word formation, and in overflow counting. Directed patterns use a zero nominal word so the accumulator freezes and each error is known exactly. These cases separate the short-direction wrap of the error, the clamping of the word at zero, saturation as opposed to wrapping of the integral sum, and the set and clear timing of the lock flag. A strobe-free run at a quarter-range word checks the pulse spacing and shows that the word holds between strobes.

// File: rtl/nco_pi_pkg.sv
package nco_pi_pkg;

  localparam int WIDE_W = 64;
  typedef logic signed [WIDE_W-1:0] wide_t;

  // Keep the low w bits of v and read them as a two's-complement number.
  function automatic wide_t wrap_to_signed(input wide_t v, input int unsigned w);
    wide_t t;
    t = v <<< (WIDE_W - w);
    return t >>> (WIDE_W - w);
  endfunction

  function automatic wide_t clamp_wide(input wide_t v, input wide_t lo, input wide_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Floor division by a power of two.
  function automatic wide_t shift_gain(input wide_t v, input logic [4:0] sh);
    return v >>> sh;
  endfunction

  function automatic logic mag_below(input wide_t v, input wide_t bound);
    wide_t m;
    m = (v < 0) ? -v : v;
    return m < bound;
  endfunction

endpackage

// File: rtl/nco_core.sv
module nco_core #(
  parameter int ACC_W     = 32,
  parameter int PPS_WRAPS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] fcw,
  output logic [ACC_W-1:0] acc_q,
  output logic             wrap_evt,
  output logic             pps_q
);

  localparam int CNT_W = (PPS_WRAPS > 1) ? $clog2(PPS_WRAPS) : 1;
  localparam logic [CNT_W-1:0] LAST_WRAP = CNT_W'(PPS_WRAPS - 1);

  logic [ACC_W:0]   acc_sum;
  logic [CNT_W-1:0] wrap_cnt;

  assign acc_sum  = {1'b0, acc_q} + {1'b0, fcw};
  assign wrap_evt = acc_sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      wrap_cnt <= '0;
      pps_q    <= 1'b0;
    end else begin
      acc_q <= acc_sum[ACC_W-1:0];
      pps_q <= 1'b0;
      if (wrap_evt) begin
        if (wrap_cnt == LAST_WRAP) begin
          wrap_cnt <= '0;
          pps_q    <= 1'b1;
        end else begin
          wrap_cnt <= wrap_cnt + 1'b1;
        end
      end
    end
  end

  // R8: a pulse is always the result of an overflow on the previous edge
  a_r8_pps_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    pps_q |-> $past(wrap_evt));

  generate
    if (PPS_WRAPS > 1) begin : g_spacing
      // R8: with more than one overflow per second, pulses are one clock wide
      a_r8_pps_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        pps_q |=> !pps_q);
    end
  endgenerate

endmodule

// File: rtl/pi_ctrl.sv
module pi_ctrl
  import nco_pi_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int INT_W = 36,
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic [ACC_W-1:0]        sample,
  input  logic [ACC_W-1:0]        target,
  input  logic [ACC_W-1:0]        nominal,
  input  logic [SH_W-1:0]         kp_sh,
  input  logic [SH_W-1:0]         ki_sh,
  output logic signed [ACC_W-1:0] err_now,
  output logic [ACC_W-1:0]        err_q,
  output logic [ACC_W-1:0]        fcw_q
);

  localparam wide_t INT_MAX = (wide_t'(1) <<< (INT_W - 1)) - 1;
  localparam wide_t INT_MIN = -INT_MAX - 1;
  localparam wide_t FCW_MAX = (wide_t'(1) <<< ACC_W) - 1;

  logic signed [INT_W-1:0] integ_q;
  wide_t err_w;
  wide_t integ_next;
  wide_t p_term;
  wide_t i_term;
  wide_t fcw_next;

  always_comb begin
    err_w      = wrap_to_signed(wide_t'(target) - wide_t'(sample), ACC_W);
    integ_next = clamp_wide(wide_t'(integ_q) + err_w, INT_MIN, INT_MAX);
    p_term     = shift_gain(err_w, 5'(kp_sh));
    i_term     = shift_gain(integ_next, 5'(ki_sh));
    fcw_next   = clamp_wide(wide_t'(nominal) + p_term + i_term, '0, FCW_MAX);
  end

  assign err_now = ACC_W'(err_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcw_q   <= nominal;
      integ_q <= '0;
      err_q   <= '0;
    end else if (strobe) begin
      fcw_q   <= ACC_W'(fcw_next);
      integ_q <= INT_W'(integ_next);
      err_q   <= ACC_W'(err_w);
    end
  end

  // R4: the control word only moves on reference arrivals
  a_r4_fcw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(fcw_q));

  // R3: the reported error holds between arrivals
  a_r3_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(err_q));

  // R5: a lag with a non-negative sum does not pull the word below nominal
  a_r5_lag_not_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (err_w > 0) && (integ_next >= 0)) |=> (fcw_q >= $past(nominal)));

endmodule

// File: rtl/lock_det.sv
module lock_det
  import nco_pi_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int LCK_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic signed [ACC_W-1:0] err,
  input  logic [ACC_W-1:0]        thresh,
  input  logic [LCK_W-1:0]        need,
  output logic                    locked_q
);

  localparam logic [LCK_W-1:0] RUN_MAX = '1;

  logic [LCK_W-1:0] run_q;
  logic [LCK_W-1:0] run_next;
  logic             good;

  always_comb begin
    good     = mag_below(wide_t'(err), wide_t'(thresh));
    run_next = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= '0;
      locked_q <= 1'b0;
    end else if (strobe) begin
      if (good) begin
        run_q    <= run_next;
        locked_q <= (run_next >= need);
      end else begin
        run_q    <= '0;
        locked_q <= 1'b0;
      end
    end
  end

  // R7: a large error on an arrival always drops lock
  a_r7_bad_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !good) |=> !locked_q);

  // R7: lock is only gained on an arrival
  a_r7_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(strobe));

endmodule

// File: rtl/nco_pi_discipline.sv
module nco_pi_discipline #(
  parameter int ACC_W     = 32,
  parameter int INT_GUARD = 4,
  parameter int SH_W      = 5,
  parameter int LCK_W     = 4,
  parameter int PPS_WRAPS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_strobe,
  input  logic [ACC_W-1:0] nominal_fcw,
  input  logic [ACC_W-1:0] target_phase,
  input  logic [SH_W-1:0]  kp_shift,
  input  logic [SH_W-1:0]  ki_shift,
  input  logic [ACC_W-1:0] lock_thresh,
  input  logic [LCK_W-1:0] lock_need,
  output logic [ACC_W-1:0] fcw,
  output logic [ACC_W-1:0] phase,
  output logic [ACC_W-1:0] phase_err,
  output logic             pps,
  output logic             locked
);

  localparam int INT_W = ACC_W + INT_GUARD;

  logic signed [ACC_W-1:0] err_now;
  logic                    wrap_evt;

  nco_core #(.ACC_W(ACC_W), .PPS_WRAPS(PPS_WRAPS)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .fcw      (fcw),
    .acc_q    (phase),
    .wrap_evt (wrap_evt),
    .pps_q    (pps)
  );

  pi_ctrl #(.ACC_W(ACC_W), .INT_W(INT_W), .SH_W(SH_W)) u_pi (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (ref_strobe),
    .sample  (phase),
    .target  (target_phase),
    .nominal (nominal_fcw),
    .kp_sh   (kp_shift),
    .ki_sh   (ki_shift),
    .err_now (err_now),
    .err_q   (phase_err),
    .fcw_q   (fcw)
  );

  lock_det #(.ACC_W(ACC_W), .LCK_W(LCK_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (ref_strobe),
    .err      (err_now),
    .thresh   (lock_thresh),
    .need     (lock_need),
    .locked_q (locked)
  );

  // R1: an overflow is seen only when the accumulator does not move forward
  a_r1_wrap_goes_down: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (phase < $past(phase)) || (phase == $past(phase)));

endmodule

// File: tb/nco_pi_discipline_tb.sv
module nco_pi_discipline_tb;

  localparam int  CLK_PERIOD = 10;
  localparam int  ACC_W      = 12;
  localparam int  INT_GUARD  = 2;
  localparam int  SH_W       = 5;
  localparam int  LCK_W      = 4;
  localparam int  PPS_WRAPS  = 4;
  localparam longint MOD     = longint'(1) << ACC_W;
  localparam longint IMAX    = (longint'(1) << (ACC_W + INT_GUARD - 1)) - 1;
  localparam longint RUNMAX  = (longint'(1) << LCK_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_strobe = 1'b0;
  logic [ACC_W-1:0] nominal_fcw = '0;
  logic [ACC_W-1:0] target_phase = '0;
  logic [SH_W-1:0]  kp_shift = '0;
  logic [SH_W-1:0]  ki_shift = '0;
  logic [ACC_W-1:0] lock_thresh = '0;
  logic [LCK_W-1:0] lock_need = '0;
  logic [ACC_W-1:0] fcw, phase, phase_err;
  logic             pps, locked;

  int n_checks = 0;
  int n_fail   = 0;

  nco_pi_discipline #(.ACC_W(ACC_W), .INT_GUARD(INT_GUARD), .SH_W(SH_W),
                      .LCK_W(LCK_W), .PPS_WRAPS(PPS_WRAPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe), .nominal_fcw(nominal_fcw),
    .target_phase(target_phase), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .lock_thresh(lock_thresh), .lock_need(lock_need), .fcw(fcw), .phase(phase),
    .phase_err(phase_err), .pps(pps), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint fdiv(input longint v, input int s);
    longint d;
    d = longint'(1) << s;
    if (v >= 0) return v / d;
    return -((-v + d - 1) / d);
  endfunction

  // Arithmetic model of the requirements.
  longint m_acc, m_fcw, m_int, m_err, m_run, m_wraps;
  bit     m_pps, m_lock, started = 1'b0;

  always @(posedge clk) begin
    started = 1'b1;
    if (!rst_n) begin
      m_acc = 0; m_fcw = longint'(nominal_fcw); m_int = 0; m_err = 0;
      m_run = 0; m_wraps = 0; m_pps = 0; m_lock = 0;
    end else begin
      longint nxt, e, i, f;
      nxt = m_acc + m_fcw;
      m_pps = 0;
      if (nxt >= MOD) begin
        if (m_wraps == PPS_WRAPS - 1) begin m_wraps = 0; m_pps = 1; end
        else m_wraps = m_wraps + 1;
      end
      if (ref_strobe) begin
        e = longint'(target_phase) - m_acc;
        if (e < 0) e = e + MOD;
        if (e >= MOD / 2) e = e - MOD;
        i = m_int + e;
        if (i > IMAX) i = IMAX;
        if (i < -IMAX - 1) i = -IMAX - 1;
        f = longint'(nominal_fcw) + fdiv(e, int'(kp_shift)) + fdiv(i, int'(ki_shift));
        if (f < 0) f = 0;
        if (f > MOD - 1) f = MOD - 1;
        if (((e < 0) ? -e : e) < longint'(lock_thresh)) begin
          if (m_run < RUNMAX) m_run = m_run + 1;
          m_lock = (m_run >= longint'(lock_need));
        end else begin
          m_run = 0; m_lock = 0;
        end
        m_err = e; m_int = i; m_fcw = f;
      end
      m_acc = nxt % MOD;
    end
  end

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      chk("R1 phase", longint'(phase), m_acc);
      chk("R5 fcw", longint'(fcw), m_fcw);
      chk("R3 phase_err", longint'($signed(phase_err)), m_err);
      chk("R8 pps", longint'(pps), longint'(m_pps));
      chk("R7 locked", longint'(locked), longint'(m_lock));
    end
  end

  task automatic do_reset(input int nom, input int tgt, input int kp, input int ki,
                          input int thr, input int need);
    @(negedge clk);
    rst_n = 1'b0; ref_strobe = 1'b0;
    nominal_fcw = ACC_W'(nom); target_phase = ACC_W'(tgt);
    kp_shift = SH_W'(kp); ki_shift = SH_W'(ki);
    lock_thresh = ACC_W'(thr); lock_need = LCK_W'(need);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe_after(input int gap);
    repeat (gap) @(negedge clk);
    ref_strobe = 1'b1;
    @(negedge clk);
    ref_strobe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int pulses;
    // R2: reset state
    do_reset(321, 0, 2, 4, 8, 3);
    chk("R2 fcw at reset", longint'(fcw), 321);
    chk("R2 phase at reset", longint'(phase), 0);
    chk("R2 pps at reset", longint'(pps), 0);
    chk("R2 locked at reset", longint'(locked), 0);
    chk("R2 phase_err at reset", longint'(phase_err), 0);

    // R8 and R4: strobe-free run at a quarter-range word
    do_reset(1024, 0, 0, 0, 0, 1);
    pulses = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (pps) pulses++;
    end
    chk("R8 pulse count in 64 clocks", pulses, 4);
    chk("R4 fcw held without strobes", longint'(fcw), 1024);

    // R3 and R5: frozen accumulator, short-direction error and clamping
    do_reset(0, 4095, 15, 15, 0, 1);
    strobe_after(3);
    chk("R3 error just ahead wraps to -1", longint'($signed(phase_err)), -1);
    chk("R5 fcw clamps at 0", longint'(fcw), 0);
    target_phase = 12'd1;
    strobe_after(2);
    chk("R3 error just behind is +1", longint'($signed(phase_err)), 1);
    target_phase = 12'h800;
    strobe_after(2);
    chk("R3 half-range error is most negative", longint'($signed(phase_err)), -2048);

    // R7: lock after three good arrivals, dropped by one bad arrival
    do_reset(0, 0, 15, 15, 1, 3);
    strobe_after(2);
    chk("R7 not locked after 1", longint'(locked), 0);
    strobe_after(2);
    chk("R7 not locked after 2", longint'(locked), 0);
    strobe_after(2);
    chk("R7 locked after 3", longint'(locked), 1);
    target_phase = 12'd1;
    strobe_after(2);
    chk("R7 bad arrival clears lock", longint'(locked), 0);

    // R6: integral saturation seen through the recovered word
    do_reset(0, 12'h800, 15, 2, 0, 1);
    for (int k = 0; k < 6; k++) strobe_after(2);
    target_phase = 12'h7FF;
    for (int k = 0; k < 4; k++) strobe_after(2);
    chk("R6 fcw still 0 after four recoveries", longint'(fcw), 0);
    strobe_after(2);
    chk("R6 saturated sum recovers to 510", longint'(fcw), 510);

    // R5 and R1: sweep of gains, periods and nominal offsets
    for (int kp = 0; kp <= 6; kp += 3) begin
      for (int ki = 3; ki <= 11; ki += 4) begin
        for (int pi = 0; pi < 3; pi++) begin
          int per, nom;
          per = (pi == 0) ? 23 : (pi == 1) ? 40 : 67;
          nom = (4096 + per / 2) / per + (kp - ki) % 4;
          do_reset(nom, (kp * 300 + ki * 17) % 4096, kp, ki, 24, 2);
          for (int s = 0; s < 16; s++) strobe_after(per - 1);
        end
      end
    end

    repeat (4) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule